// File: doc/BRIEF.md
# UART Register and Interrupt Front End

This block is the software-facing side of a serial port. A bus master performs 32-bit word accesses through a single-cycle request: `busValid` with `busWrite`, a byte address and write data. The block holds the interrupt pending and mask registers, the line control word, the queue control word and two general configuration words. The transmit and receive datapaths feed it their level counts and flags, and it folds these into the read-only status and queue-level words.

It drives four level-sensitive interrupt lines. It also sends one-cycle strobes back to the datapaths:
- a push strobe, with a byte, when software writes transmit data;
- a pop strobe when software takes a received byte;
- a reset strobe for each queue.

Hardware events set pending bits directly. Software clears a pending bit by writing a one to it, and can force any pending bit set through a separate test offset.

Every register update, read response and strobe becomes visible in the cycle after the clock edge that samples the access.

Top module: `uart_regfront`

## Requirements
- R1: After reset, every offset reads zero except the status word. The status word reads 0x0000003C while the datapath reports both queues empty and both sides idle. All interrupt lines and strobes are low.
- R2: Pending bit 0 is transmit watermark, bit 1 is receive watermark, bit 2 is transmit empty and bit 3 is receive overflow. A one-cycle pulse on the matching event input sets that bit. The pending word is read at offset 0x00.
- R3: A write to offset 0x00 clears each pending bit whose data bit is one and leaves the other pending bits unchanged.
- R4: A write to offset 0x08 ORs data bits 3:0 into the pending bits.
- R5: Each interrupt line is high exactly when its pending bit and its mask bit are both set. The mask is written and read at offset 0x04 and holds bits 3:0 only.
- R6: If a hardware event and a clearing write hit the same bit in one cycle, the bit ends up set.
- R7: The status word at offset 0x14 is built as follows, with all other bits zero:
  - bit 0: transmit full
  - bit 1: receive full
  - bit 2: transmit empty
  - bit 3: transmit idle
  - bit 4: receive idle
  - bit 5: receive empty
- R8: The level word at offset 0x24 carries the transmit level in bits 4:0 and the receive level in bits 20:16.
- R9: A write to offset 0x20 stores data bits 6:0, which read back. If data bit 0 is set, the write raises a one-cycle receive-queue reset strobe. If data bit 1 is set, it raises a one-cycle transmit-queue reset strobe.
- R10: Writes to offsets 0x0C, 0x14, 0x18, 0x24 and 0x2C change no state and raise no strobe. Offsets 0x08, 0x0C, 0x1C and 0x2C read zero.
- R11: A read of offset 0x18 returns the receive byte in bits 7:0. It raises a one-cycle pop strobe only when control bit 1 (receive enable) is set and the receive level is nonzero.
- R12: Each write to offset 0x1C raises a one-cycle push strobe that carries data bits 7:0.
- R13: A read of an unmapped offset returns zero and raises a one-cycle error flag. Unmapped offsets are 0x34 and above, within the 1 KiB window. A write to an unmapped offset changes nothing.
- R14: The control word (0x10), override word (0x28) and timeout word (0x30) hold all 32 written bits and read them back. The control word is also driven out to the datapath.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Access request, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | AddrW | Byte address (bits 1:0 ignored) |
| busWdata | input | 32 | Write data |
| rdData | output | 32 | Read response, valid the cycle after a read |
| rdErr | output | 1 | One-cycle flag for a read of an unmapped offset |
| txLevel | input | LvlW | Transmit queue level |
| rxLevel | input | LvlW | Receive queue level |
| txFull | input | 1 | Transmit queue full |
| rxFull | input | 1 | Receive queue full |
| txEmpty | input | 1 | Transmit queue empty |
| txIdle | input | 1 | Transmitter idle |
| rxIdle | input | 1 | Receiver idle |
| rxEmpty | input | 1 | Receive queue empty |
| rxData | input | 8 | Byte at the head of the receive queue |
| evTxWatermark | input | 1 | Event: transmit watermark reached |
| evRxWatermark | input | 1 | Event: receive watermark reached |
| evTxEmpty | input | 1 | Event: transmit queue drained |
| evRxOverflow | input | 1 | Event: receive overflow |
| irqTxWatermark | output | 1 | Interrupt line, pending bit 0 |
| irqRxWatermark | output | 1 | Interrupt line, pending bit 1 |
| irqTxEmpty | output | 1 | Interrupt line, pending bit 2 |
| irqRxOverflow | output | 1 | Interrupt line, pending bit 3 |
| txPush | output | 1 | One-cycle push strobe |
| txPushData | output | 8 | Byte carried by the push strobe |
| rxPop | output | 1 | One-cycle pop strobe |
| txFifoRst | output | 1 | One-cycle transmit-queue reset strobe |
| rxFifoRst | output | 1 | One-cycle receive-queue reset strobe |
| ctrlWord | output | 32 | Current control word |
| fifoCtrlWord | output | 7 | Current queue control bits |

## Verification
The pending logic is driven by three sources: hardware events, test writes and clearing writes. It is exercised with:
- partial clear masks (0x5, then 0xA), which separate a per-bit clear from a whole-word clear;
- a test write over an already-set bit, which separates OR from overwrite;
- an event arriving in the same cycle as a clear of the same bit, which shows which source wins.

The interrupt lines are checked under several mask patterns, so a line wired to the wrong bit, or gated by the pending bit alone, shows up.

The status and level words are read under opposing flag and level patterns, so that swapped or shifted fields are exposed.

The pop strobe is tried with:
- receive enabled and level zero;
- receive enabled and level nonzero;
- receive disabled and level nonzero.

These separate the two gating conditions.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;

  localparam int NumIrq = 4;

  typedef enum logic [3:0] {
    IdxIntrState  = 4'd0,
    IdxIntrEnable = 4'd1,
    IdxIntrTest   = 4'd2,
    IdxAlertTest  = 4'd3,
    IdxCtrl       = 4'd4,
    IdxStatus     = 4'd5,
    IdxRxData     = 4'd6,
    IdxTxData     = 4'd7,
    IdxFifoCtrl   = 4'd8,
    IdxFifoStatus = 4'd9,
    IdxOvrd       = 4'd10,
    IdxValue      = 4'd11,
    IdxTimeout    = 4'd12,
    IdxNone       = 4'd15
  } regIdx_e;

  // Strobes from the decoder to the register datapath, valid in the access cycle
  typedef struct packed {
    logic    wrIntrState;
    logic    wrIntrEnable;
    logic    wrIntrTest;
    logic    wrCtrl;
    logic    wrFifoCtrl;
    logic    wrOvrd;
    logic    wrTimeout;
    logic    wrTxData;
    logic    rdEn;
    logic    rdRxData;
    logic    rdBad;
    regIdx_e rdSel;
  } regStrb_t;

endpackage

// File: rtl/uart_regfront_ctrl.sv
module uart_regfront_ctrl
  import uart_regfront_pkg::*;
#(
  parameter int AddrW = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busValid,
  input  logic             busWrite,
  input  logic [AddrW-1:0] busAddr,
  output regStrb_t         strb
);

  localparam int IdxLsb  = 2;
  localparam int IdxMsb  = 5;
  localparam int LastIdx = 12;

  logic [3:0] wordIdx;
  logic       inWindow;
  logic       mapped;

  assign wordIdx = busAddr[IdxMsb:IdxLsb];

  generate
    if (AddrW > IdxMsb + 1) begin : g_upper
      assign inWindow = (busAddr[AddrW-1:IdxMsb+1] == '0);
    end else begin : g_flat
      assign inWindow = 1'b1;
    end
  endgenerate

  assign mapped = inWindow && (wordIdx <= 4'(LastIdx));

  always_comb begin
    strb       = '0;
    strb.rdSel = IdxNone;
    if (busValid && busWrite && mapped) begin
      case (regIdx_e'(wordIdx))
        IdxIntrState:  strb.wrIntrState  = 1'b1;
        IdxIntrEnable: strb.wrIntrEnable = 1'b1;
        IdxIntrTest:   strb.wrIntrTest   = 1'b1;
        IdxCtrl:       strb.wrCtrl       = 1'b1;
        IdxTxData:     strb.wrTxData     = 1'b1;
        IdxFifoCtrl:   strb.wrFifoCtrl   = 1'b1;
        IdxOvrd:       strb.wrOvrd       = 1'b1;
        IdxTimeout:    strb.wrTimeout    = 1'b1;
        default:       ;
      endcase
    end
    if (busValid && !busWrite) begin
      if (mapped) begin
        strb.rdEn     = 1'b1;
        strb.rdSel    = regIdx_e'(wordIdx);
        strb.rdRxData = (regIdx_e'(wordIdx) == IdxRxData);
      end else begin
        strb.rdBad = 1'b1;
      end
    end
  end

  // R10
  one_write_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrIntrState, strb.wrIntrEnable, strb.wrIntrTest, strb.wrCtrl,
              strb.wrFifoCtrl, strb.wrOvrd, strb.wrTimeout, strb.wrTxData}));

  // R13
  bad_read_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdBad |-> !strb.rdEn && !strb.rdRxData);

endmodule

// File: rtl/uart_regfront_data.sv
module uart_regfront_data
  import uart_regfront_pkg::*;
#(
  parameter int LvlW = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrb_t          strb,
  input  logic [31:0]       wdata,
  input  logic [LvlW-1:0]   txLevel,
  input  logic [LvlW-1:0]   rxLevel,
  input  logic [5:0]        flagsIn,
  input  logic [7:0]        rxData,
  input  logic [NumIrq-1:0] evSet,
  output logic [NumIrq-1:0] irq,
  output logic [31:0]       rdData,
  output logic              rdErr,
  output logic              txPush,
  output logic [7:0]        txPushData,
  output logic              rxPop,
  output logic              txFifoRst,
  output logic              rxFifoRst,
  output logic [31:0]       ctrlWord,
  output logic [6:0]        fifoCtrlWord
);

  localparam int FifoCtrlW = 7;
  localparam int RxLvlLsb  = 16;
  localparam int RxEnBit   = 1;
  localparam int RxRstBit  = 0;
  localparam int TxRstBit  = 1;

  logic [NumIrq-1:0]    intrState;
  logic [NumIrq-1:0]    intrEnable;
  logic [NumIrq-1:0]    intrNext;
  logic [NumIrq-1:0]    clrMask;
  logic [NumIrq-1:0]    setMask;
  logic [31:0]          ctrlReg;
  logic [FifoCtrlW-1:0] fifoCtrl;
  logic [31:0]          ovrdReg;
  logic [31:0]          timeoutReg;
  logic [31:0]          statusWord;
  logic [31:0]          levelWord;
  logic [31:0]          rdMux;

  // Set sources win over a clear of the same bit
  always_comb begin
    clrMask  = strb.wrIntrState ? wdata[NumIrq-1:0] : '0;
    setMask  = evSet | (strb.wrIntrTest ? wdata[NumIrq-1:0] : '0);
    intrNext = (intrState & ~clrMask) | setMask;
  end

  assign statusWord = {26'b0, flagsIn};
  assign levelWord  = (32'(rxLevel) << RxLvlLsb) | 32'(txLevel);

  always_comb begin
    case (strb.rdSel)
      IdxIntrState:  rdMux = 32'(intrState);
      IdxIntrEnable: rdMux = 32'(intrEnable);
      IdxCtrl:       rdMux = ctrlReg;
      IdxStatus:     rdMux = statusWord;
      IdxRxData:     rdMux = 32'(rxData);
      IdxFifoCtrl:   rdMux = 32'(fifoCtrl);
      IdxFifoStatus: rdMux = levelWord;
      IdxOvrd:       rdMux = ovrdReg;
      IdxTimeout:    rdMux = timeoutReg;
      default:       rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intrState  <= '0;
      intrEnable <= '0;
      ctrlReg    <= '0;
      fifoCtrl   <= '0;
      ovrdReg    <= '0;
      timeoutReg <= '0;
      rdData     <= '0;
      rdErr      <= 1'b0;
      txPush     <= 1'b0;
      txPushData <= '0;
      rxPop      <= 1'b0;
      txFifoRst  <= 1'b0;
      rxFifoRst  <= 1'b0;
    end else begin
      intrState <= intrNext;
      if (strb.wrIntrEnable) intrEnable <= wdata[NumIrq-1:0];
      if (strb.wrCtrl)       ctrlReg    <= wdata;
      if (strb.wrFifoCtrl)   fifoCtrl   <= wdata[FifoCtrlW-1:0];
      if (strb.wrOvrd)       ovrdReg    <= wdata;
      if (strb.wrTimeout)    timeoutReg <= wdata;
      txPush <= strb.wrTxData;
      if (strb.wrTxData) txPushData <= wdata[7:0];
      rxPop     <= strb.rdRxData && ctrlReg[RxEnBit] && (rxLevel != '0);
      rxFifoRst <= strb.wrFifoCtrl && wdata[RxRstBit];
      txFifoRst <= strb.wrFifoCtrl && wdata[TxRstBit];
      rdErr     <= strb.rdBad;
      if (strb.rdEn || strb.rdBad) rdData <= strb.rdBad ? '0 : rdMux;
    end
  end

  assign irq          = intrState & intrEnable;
  assign ctrlWord     = ctrlReg;
  assign fifoCtrlWord = fifoCtrl;

  // R3
  clear_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrIntrState && (wdata[NumIrq-1:0] == '1) && (evSet == '0)) |=> (irq == '0));

  // R4
  test_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrIntrTest |=> ((intrState & $past(wdata[NumIrq-1:0])) == $past(wdata[NumIrq-1:0])));

  // R6
  event_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evSet != '0) |=> ((intrState & $past(evSet)) == $past(evSet)));

  // R12
  push_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrTxData |=> (txPush && (txPushData == $past(wdata[7:0]))));

  // R11
  pop_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |-> $past(strb.rdRxData));

  // R13
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |-> (rdData == '0));

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_regfront_pkg::*;
#(
  parameter int AddrW = 10,
  parameter int LvlW  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busValid,
  input  logic             busWrite,
  input  logic [AddrW-1:0] busAddr,
  input  logic [31:0]      busWdata,
  output logic [31:0]      rdData,
  output logic             rdErr,
  input  logic [LvlW-1:0]  txLevel,
  input  logic [LvlW-1:0]  rxLevel,
  input  logic             txFull,
  input  logic             rxFull,
  input  logic             txEmpty,
  input  logic             txIdle,
  input  logic             rxIdle,
  input  logic             rxEmpty,
  input  logic [7:0]       rxData,
  input  logic             evTxWatermark,
  input  logic             evRxWatermark,
  input  logic             evTxEmpty,
  input  logic             evRxOverflow,
  output logic             irqTxWatermark,
  output logic             irqRxWatermark,
  output logic             irqTxEmpty,
  output logic             irqRxOverflow,
  output logic             txPush,
  output logic [7:0]       txPushData,
  output logic             rxPop,
  output logic             txFifoRst,
  output logic             rxFifoRst,
  output logic [31:0]      ctrlWord,
  output logic [6:0]       fifoCtrlWord
);

  regStrb_t          strb;
  logic [NumIrq-1:0] evSet;
  logic [NumIrq-1:0] irq;
  logic [5:0]        flagsIn;

  assign evSet   = {evRxOverflow, evTxEmpty, evRxWatermark, evTxWatermark};
  assign flagsIn = {rxEmpty, rxIdle, txIdle, txEmpty, rxFull, txFull};

  uart_regfront_ctrl #(.AddrW(AddrW)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strb     (strb)
  );

  uart_regfront_data #(.LvlW(LvlW)) data_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .wdata        (busWdata),
    .txLevel      (txLevel),
    .rxLevel      (rxLevel),
    .flagsIn      (flagsIn),
    .rxData       (rxData),
    .evSet        (evSet),
    .irq          (irq),
    .rdData       (rdData),
    .rdErr        (rdErr),
    .txPush       (txPush),
    .txPushData   (txPushData),
    .rxPop        (rxPop),
    .txFifoRst    (txFifoRst),
    .rxFifoRst    (rxFifoRst),
    .ctrlWord     (ctrlWord),
    .fifoCtrlWord (fifoCtrlWord)
  );

  assign irqTxWatermark = irq[0];
  assign irqRxWatermark = irq[1];
  assign irqTxEmpty     = irq[2];
  assign irqRxOverflow  = irq[3];

endmodule

// File: tb/uart_regfront_tb_top.sv
module uart_regfront_tb_top;

  localparam logic [9:0] AIntrState = 10'h000, AIntrEnable = 10'h004, AIntrTest = 10'h008,
                         AAlert = 10'h00C, ACtrl = 10'h010, AStatus = 10'h014,
                         ARxData = 10'h018, ATxData = 10'h01C, AFifoCtrl = 10'h020,
                         AFifoStatus = 10'h024, AOvrd = 10'h028, AValue = 10'h02C,
                         ATimeout = 10'h030;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [9:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] rdData;
  logic        rdErr;
  logic [4:0]  txLevel = '0, rxLevel = '0;
  logic        txFull = 1'b0, rxFull = 1'b0, txEmpty = 1'b1, txIdle = 1'b1;
  logic        rxIdle = 1'b1, rxEmpty = 1'b1;
  logic [7:0]  rxData = '0;
  logic        evTxWatermark = 1'b0, evRxWatermark = 1'b0, evTxEmpty = 1'b0, evRxOverflow = 1'b0;
  logic        irqTxWatermark, irqRxWatermark, irqTxEmpty, irqRxOverflow;
  logic        txPush, rxPop, txFifoRst, rxFifoRst;
  logic [7:0]  txPushData;
  logic [31:0] ctrlWord;
  logic [6:0]  fifoCtrlWord;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } exp_t;
  exp_t expQ[$];
  logic respDue = 1'b0;

  always #10 clk = ~clk;

  uart_regfront dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .rdData(rdData), .rdErr(rdErr), .txLevel(txLevel), .rxLevel(rxLevel),
    .txFull(txFull), .rxFull(rxFull), .txEmpty(txEmpty), .txIdle(txIdle), .rxIdle(rxIdle),
    .rxEmpty(rxEmpty), .rxData(rxData), .evTxWatermark(evTxWatermark),
    .evRxWatermark(evRxWatermark), .evTxEmpty(evTxEmpty), .evRxOverflow(evRxOverflow),
    .irqTxWatermark(irqTxWatermark), .irqRxWatermark(irqRxWatermark), .irqTxEmpty(irqTxEmpty),
    .irqRxOverflow(irqRxOverflow), .txPush(txPush), .txPushData(txPushData), .rxPop(rxPop),
    .txFifoRst(txFifoRst), .rxFifoRst(rxFifoRst), .ctrlWord(ctrlWord), .fifoCtrlWord(fifoCtrlWord)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] irqVec();
    return {28'b0, irqRxOverflow, irqTxEmpty, irqRxWatermark, irqTxWatermark};
  endfunction

  function automatic logic [31:0] strobes();
    return {28'b0, txPush, rxPop, txFifoRst, rxFifoRst};
  endfunction

  // Driver: each read queues the response expected one cycle later
  task automatic rd(input logic [9:0] a, input logic [31:0] e, input logic eErr, input string tag);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    expQ.push_back('{data: e, err: eErr, tag: tag});
    @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  // Monitor: compares each read response against the scoreboard
  always @(posedge clk) respDue <= busValid && !busWrite && rstN;
  always @(negedge clk) begin
    if (respDue) begin
      if (expQ.size() == 0) begin
        chk("scoreboard underflow", 32'd1, 32'd0);
      end else begin
        exp_t it;
        it = expQ.pop_front();
        chk(it.tag, rdData, it.data);
        chk({it.tag, " err"}, {31'b0, rdErr}, {31'b0, it.err});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", irqVec(), 32'h0);
    chk("R1 strobes", strobes(), 32'h0);
    chk("R1 ctrl out", ctrlWord, 32'h0);
    rd(AIntrState, 32'h0, 1'b0, "R1 state");
    rd(AIntrEnable, 32'h0, 1'b0, "R1 enable");
    rd(ACtrl, 32'h0, 1'b0, "R1 ctrl");
    rd(AStatus, 32'h3C, 1'b0, "R1 status");
    rd(AFifoCtrl, 32'h0, 1'b0, "R1 fifoctrl");
    rd(AFifoStatus, 32'h0, 1'b0, "R1 levels");
    rd(AOvrd, 32'h0, 1'b0, "R1 ovrd");
    rd(ATimeout, 32'h0, 1'b0, "R1 timeout");

    // R2 hardware event sets its bit
    evTxEmpty = 1'b1; @(negedge clk); evTxEmpty = 1'b0;
    rd(AIntrState, 32'h4, 1'b0, "R2 tx empty event");
    chk("R5 masked off", irqVec(), 32'h0);

    // R5 mask gating
    wr(AIntrEnable, 32'h4);
    chk("R5 single line", irqVec(), 32'h4);
    wr(AIntrEnable, 32'hFFFF_FFFF);
    rd(AIntrEnable, 32'hF, 1'b0, "R5 enable width");
    chk("R5 full mask", irqVec(), 32'h4);

    // R4 test OR
    wr(AIntrTest, 32'hB);
    chk("R4 lines after test", irqVec(), 32'hF);
    rd(AIntrState, 32'hF, 1'b0, "R4 state OR");

    // R3 per-bit clear
    wr(AIntrState, 32'h5);
    chk("R3 lines after clear", irqVec(), 32'hA);
    rd(AIntrState, 32'hA, 1'b0, "R3 partial clear");
    wr(AIntrState, 32'hA);
    rd(AIntrState, 32'h0, 1'b0, "R3 clear rest");

    // R6 event beats clear
    evTxWatermark = 1'b1;
    wr(AIntrState, 32'h1);
    evTxWatermark = 1'b0;
    rd(AIntrState, 32'h1, 1'b0, "R6 set wins");
    evRxOverflow = 1'b1; @(negedge clk); evRxOverflow = 1'b0;
    wr(AIntrEnable, 32'h8);
    chk("R5 overflow line", irqVec(), 32'h8);
    wr(AIntrState, 32'hF);
    wr(AIntrEnable, 32'h0);

    // R14 config words
    wr(ACtrl, 32'hA5A5_0003);
    chk("R14 ctrl out", ctrlWord, 32'hA5A5_0003);
    rd(ACtrl, 32'hA5A5_0003, 1'b0, "R14 ctrl");
    wr(AOvrd, 32'h0000_0013);
    rd(AOvrd, 32'h0000_0013, 1'b0, "R14 ovrd");
    wr(ATimeout, 32'h80FF_1234);
    rd(ATimeout, 32'h80FF_1234, 1'b0, "R14 timeout");

    // R7 status layout
    txFull = 1'b1; rxFull = 1'b1; txEmpty = 1'b0; txIdle = 1'b0; rxIdle = 1'b0; rxEmpty = 1'b0;
    rd(AStatus, 32'h03, 1'b0, "R7 full pattern");
    txFull = 1'b0; rxFull = 1'b0; txIdle = 1'b1; rxEmpty = 1'b1;
    rd(AStatus, 32'h28, 1'b0, "R7 mixed pattern");

    // R8 level word
    txLevel = 5'h13; rxLevel = 5'h0A;
    rd(AFifoStatus, 32'h000A_0013, 1'b0, "R8 levels");
    txLevel = 5'h1F; rxLevel = 5'h01;
    rd(AFifoStatus, 32'h0001_001F, 1'b0, "R8 levels max");

    // R9 queue control
    wr(AFifoCtrl, 32'hFFFF_FF7D);
    chk("R9 rx reset only", strobes(), 32'h1);
    @(negedge clk);
    chk("R9 strobe one cycle", strobes(), 32'h0);
    rd(AFifoCtrl, 32'h7D, 1'b0, "R9 readback");
    wr(AFifoCtrl, 32'h02);
    chk("R9 tx reset only", strobes(), 32'h2);
    chk("R9 out word", {25'b0, fifoCtrlWord}, 32'h02);

    // R10 no-effect writes
    wr(AStatus, 32'hFFFF_FFFF);
    wr(ARxData, 32'hFFFF_FFFF);
    chk("R10 rdata write no strobe", strobes(), 32'h0);
    wr(AFifoStatus, 32'hFFFF_FFFF);
    wr(AValue, 32'hFFFF_FFFF);
    wr(AAlert, 32'hFFFF_FFFF);
    chk("R10 alert write no irq", irqVec(), 32'h0);
    rd(AStatus, 32'h28, 1'b0, "R10 status unchanged");
    rd(AFifoStatus, 32'h0001_001F, 1'b0, "R10 levels unchanged");
    rd(AValue, 32'h0, 1'b0, "R10 value zero");
    rd(AAlert, 32'h0, 1'b0, "R10 alert zero");
    rd(ATxData, 32'h0, 1'b0, "R10 txdata reads zero");
    rd(AIntrTest, 32'h0, 1'b0, "R10 test reads zero");
    rd(AIntrState, 32'h0, 1'b0, "R10 state unchanged");

    // R11 pop gating (ctrl bit 1 currently set)
    rxData = 8'h5A; rxLevel = 5'd0;
    rd(ARxData, 32'h5A, 1'b0, "R11 byte");
    chk("R11 no pop at level 0", {31'b0, rxPop}, 32'h0);
    rxLevel = 5'd3; rxData = 8'hC7;
    rd(ARxData, 32'hC7, 1'b0, "R11 byte 2");
    chk("R11 pop", {31'b0, rxPop}, 32'h1);
    @(negedge clk);
    chk("R11 pop one cycle", {31'b0, rxPop}, 32'h0);
    wr(ACtrl, 32'h0000_0001);
    rd(ARxData, 32'hC7, 1'b0, "R11 byte 3");
    chk("R11 no pop when disabled", {31'b0, rxPop}, 32'h0);

    // R12 push strobe
    wr(ATxData, 32'h1234_56C3);
    chk("R12 push", {23'b0, txPush, txPushData}, {23'b0, 1'b1, 8'hC3});
    wr(ATxData, 32'h0000_0081);
    chk("R12 back-to-back", {23'b0, txPush, txPushData}, {23'b0, 1'b1, 8'h81});
    @(negedge clk);
    chk("R12 push one cycle", {31'b0, txPush}, 32'h0);

    // R13 unmapped offsets
    rd(10'h034, 32'h0, 1'b1, "R13 first hole");
    rd(10'h3FC, 32'h0, 1'b1, "R13 top of window");
    rd(ACtrl, 32'h0000_0001, 1'b0, "R13 err clears");
    wr(10'h050, 32'hDEAD_BEEF);
    wr(10'h210, 32'hDEAD_BEEF);
    rd(ACtrl, 32'h0000_0001, 1'b0, "R13 write ignored");
    rd(AIntrState, 32'h0, 1'b0, "R13 state intact");

    repeat (3) @(negedge clk);
    chk("scoreboard drained", expQ.size(), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule